// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated Immediates

This block produces the second operand of a data-processing instruction together with the shifter carry that the flag logic may later consume. It takes the 12-bit operand field of the instruction and works in one of two forms. In the immediate form it builds a 32-bit constant from an 8-bit value rotated right by an even amount. In the register form it applies a logical left shift, logical right shift, arithmetic right shift, rotate right, or a one-bit rotate right through the carry flag to a register value. The shift amount comes from the field itself or from the low byte of a second register.

The datapath is combinational. A single output register stage, qualified by a valid strobe, holds the operand and carry for the next pipeline stage. The register indices in the field are resolved upstream, and the block receives the register contents directly. The ALU and flag writeback sit outside the block.

Top module: `opnd_shifter`

## Requirements
- R1: With `imm_sel` high, `op_field[7:0]` is zero-extended to 32 bits and rotated right by twice `op_field[11:8]`, so the rotation is an even amount from 0 to 30. The result is the operand.
- R2: With `imm_sel` high, the carry-out equals `carry_in` when `op_field[11:8]` is 0. Otherwise it equals bit 31 of the produced operand.
- R3: In the register form the field is laid out as follows. `op_field[11:7]` is the immediate amount. `op_field[6:5]` selects the shift kind: 0 is left logical, 1 is right logical, 2 is right arithmetic, 3 is rotate right. `op_field[4]` set takes the amount from `amt_reg`, and clear takes it from the field. With an immediate amount, a left shift by 1 to 31 fills with zeros and the carry is the last bit shifted out. A left shift by 0 passes `rm_val` and `carry_in` through unchanged.
- R4: With an immediate amount (`op_field[4]`=0), a logical right shift fills with zeros and an arithmetic right shift copies bit 31. The carry is the last bit shifted out. An encoded amount of 0 means a shift by 32 for both kinds.
- R5: With an immediate amount, a rotate right by 1 to 31 wraps the low bits into the top, and the carry is bit 31 of the result. An encoded amount of 0 selects the one-bit rotate through carry instead. In that case `carry_in` enters bit 31 and the old bit 0 becomes the carry-out.
- R6: With `op_field[4]`=1 and `amt_reg` equal to 0, every shift kind passes `rm_val` and `carry_in` through unchanged.
- R7: With a register amount, a left or right logical shift by exactly 32 gives 0. The carry is bit 0 for a left shift and bit 31 for a right shift. Any amount above 32 gives 0 with carry 0.
- R8: With a register amount of 32 or more, an arithmetic right shift fills every bit with bit 31 of `rm_val`, and the carry equals that bit.
- R9: With a register amount, a rotate right uses the amount modulo 32. A nonzero multiple of 32 leaves the value unchanged and sets the carry to bit 31.
- R10: Operand and carry appear one clock after a cycle with `in_valid` high. `out_valid` is high in exactly those cycles and is low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| imm_sel | input | 1 | 1: rotated-immediate form, 0: register form |
| op_field | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value of the register being shifted |
| amt_reg | input | 8 | Low byte of the register that holds the shift amount |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered result is valid |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Every result, in both the immediate and register forms, is due exactly one rising edge after the cycle in which its inputs were presented with `in_valid` high. There is no other latency in the block. The driver changes inputs just after a rising edge and queues the expected operand and carry at the same moment. The monitor looks at the outputs on the following falling edge and pops one entry for each cycle in which `out_valid` is high. A valid output with an empty queue, or a valid output in the cycle after an idle input, counts as a timing failure against R10.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned FIELD_W = 12;
  localparam int unsigned IMM8_W  = 8;
  localparam int unsigned ROTF_W  = 4;
  localparam int unsigned AMTF_W  = 5;
  localparam int unsigned AMTR_W  = 8;

  typedef enum logic [1:0] {
    SK_LSL = 2'd0,
    SK_LSR = 2'd1,
    SK_ASR = 2'd2,
    SK_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic [AMTF_W-1:0] amt_imm;
    shift_kind_e       kind;
    logic              amt_by_reg;
    logic [3:0]        reg_index;
  } reg_field_t;

endpackage

// File: rtl/opnd_imm_rotator.sv
module opnd_imm_rotator
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned IMM_W  = IMM8_W,
  parameter int unsigned ROT_W  = ROTF_W
) (
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [ROT_W-1:0]  rot_cnt,
  input  logic              carry_in,
  output logic [DATA_W-1:0] value,
  output logic              carry_out
);

  // stage k rotates right by 2*2^k when rot_cnt[k] is set
  logic [DATA_W-1:0] stage [ROT_W+1];

  assign stage[0] = {{(DATA_W-IMM_W){1'b0}}, imm_val};

  for (genvar k = 0; k < ROT_W; k++) begin : g_rot_stage
    localparam int unsigned STEP = 2 << k;
    always_comb begin
      if (rot_cnt[k]) begin
        stage[k+1] = {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]};
      end else begin
        stage[k+1] = stage[k];
      end
    end
  end

  assign value = stage[ROT_W];

  always_comb begin
    if (rot_cnt == '0) begin
      carry_out = carry_in;
    end else begin
      carry_out = value[DATA_W-1];
    end
  end

endmodule

// File: rtl/opnd_amt_decode.sv
module opnd_amt_decode
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned IMMA_W = AMTF_W,
  parameter int unsigned REGA_W = AMTR_W,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic              by_reg,
  input  shift_kind_e       kind,
  input  logic [IMMA_W-1:0] amt_imm,
  input  logic [REGA_W-1:0] amt_reg,
  output logic              pass_thru,
  output logic              do_rrx,
  output logic              amt_full,
  output logic              amt_over,
  output logic [SH_W-1:0]   amt_low
);

  localparam logic [REGA_W-1:0] FULL_AMT = REGA_W'(DATA_W);

  always_comb begin
    pass_thru = 1'b0;
    do_rrx    = 1'b0;
    amt_full  = 1'b0;
    amt_over  = 1'b0;
    amt_low   = '0;
    if (!by_reg) begin
      amt_low = SH_W'(amt_imm);
      if (amt_imm == '0) begin
        unique case (kind)
          SK_LSL:         pass_thru = 1'b1;
          SK_LSR, SK_ASR: amt_full  = 1'b1;
          SK_ROR:         do_rrx    = 1'b1;
          default:        pass_thru = 1'b1;
        endcase
      end
    end else begin
      amt_low = amt_reg[SH_W-1:0];
      if (amt_reg == '0) begin
        pass_thru = 1'b1;
      end else if (kind != SK_ROR) begin
        amt_full = (amt_reg == FULL_AMT);
        amt_over = (amt_reg >  FULL_AMT);
      end
    end
  end

endmodule

// File: rtl/opnd_reg_shifter.sv
module opnd_reg_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  shift_kind_e       kind,
  input  logic              carry_in,
  input  logic              pass_thru,
  input  logic              do_rrx,
  input  logic              amt_full,
  input  logic              amt_over,
  input  logic [SH_W-1:0]   amt_low,
  output logic [DATA_W-1:0] value,
  output logic              carry_out
);

  localparam logic [SH_W:0] WIDTH_V = (SH_W+1)'(DATA_W);

  logic [SH_W:0]     lsl_idx;
  logic [SH_W-1:0]   rsh_idx;
  logic [DATA_W-1:0] ror_val;
  logic              sign_bit;

  assign lsl_idx  = WIDTH_V - {1'b0, amt_low};
  assign rsh_idx  = amt_low - SH_W'(1);
  assign sign_bit = src[DATA_W-1];

  // barrel rotate right by amt_low, one stage per amount bit
  logic [DATA_W-1:0] rstage [SH_W+1];
  assign rstage[0] = src;
  for (genvar k = 0; k < SH_W; k++) begin : g_ror_stage
    localparam int unsigned STEP = 1 << k;
    always_comb begin
      if (amt_low[k]) begin
        rstage[k+1] = {rstage[k][STEP-1:0], rstage[k][DATA_W-1:STEP]};
      end else begin
        rstage[k+1] = rstage[k];
      end
    end
  end
  assign ror_val = rstage[SH_W];

  always_comb begin
    value     = src;
    carry_out = carry_in;
    if (!pass_thru) begin
      unique case (kind)
        SK_LSL: begin
          if (amt_over) begin
            value = '0; carry_out = 1'b0;
          end else if (amt_full) begin
            value = '0; carry_out = src[0];
          end else begin
            value     = src << amt_low;
            carry_out = src[lsl_idx[SH_W-1:0]];
          end
        end
        SK_LSR: begin
          if (amt_over) begin
            value = '0; carry_out = 1'b0;
          end else if (amt_full) begin
            value = '0; carry_out = sign_bit;
          end else begin
            value     = src >> amt_low;
            carry_out = src[rsh_idx];
          end
        end
        SK_ASR: begin
          if (amt_over || amt_full) begin
            value = {DATA_W{sign_bit}}; carry_out = sign_bit;
          end else begin
            value     = $signed(src) >>> amt_low;
            carry_out = src[rsh_idx];
          end
        end
        SK_ROR: begin
          if (do_rrx) begin
            value     = {carry_in, src[DATA_W-1:1]};
            carry_out = src[0];
          end else begin
            value     = ror_val;
            carry_out = ror_val[DATA_W-1];
          end
        end
        default: begin
          value = src; carry_out = carry_in;
        end
      endcase
    end
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               imm_sel,
  input  logic [FIELD_W-1:0] op_field,
  input  logic [DATA_W-1:0]  rm_val,
  input  logic [AMTR_W-1:0]  amt_reg,
  input  logic               carry_in,
  output logic               out_valid,
  output logic [DATA_W-1:0]  operand,
  output logic               carry_out
);

  reg_field_t fld;
  assign fld = reg_field_t'(op_field);

  // immediate form
  logic [DATA_W-1:0] imm_value;
  logic              imm_carry;

  opnd_imm_rotator #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM8_W),
    .ROT_W  (ROTF_W)
  ) u_imm (
    .imm_val   (op_field[IMM8_W-1:0]),
    .rot_cnt   (op_field[IMM8_W+ROTF_W-1:IMM8_W]),
    .carry_in  (carry_in),
    .value     (imm_value),
    .carry_out (imm_carry)
  );

  // register form
  logic            dec_pass, dec_rrx, dec_full, dec_over;
  logic [SH_W-1:0] dec_low;

  opnd_amt_decode #(
    .DATA_W (DATA_W),
    .IMMA_W (AMTF_W),
    .REGA_W (AMTR_W)
  ) u_dec (
    .by_reg    (fld.amt_by_reg),
    .kind      (fld.kind),
    .amt_imm   (fld.amt_imm),
    .amt_reg   (amt_reg),
    .pass_thru (dec_pass),
    .do_rrx    (dec_rrx),
    .amt_full  (dec_full),
    .amt_over  (dec_over),
    .amt_low   (dec_low)
  );

  logic [DATA_W-1:0] reg_value;
  logic              reg_carry;

  opnd_reg_shifter #(
    .DATA_W (DATA_W)
  ) u_shf (
    .src       (rm_val),
    .kind      (fld.kind),
    .carry_in  (carry_in),
    .pass_thru (dec_pass),
    .do_rrx    (dec_rrx),
    .amt_full  (dec_full),
    .amt_over  (dec_over),
    .amt_low   (dec_low),
    .value     (reg_value),
    .carry_out (reg_carry)
  );

  // next state
  logic              vld_d;
  logic [DATA_W-1:0] opnd_d;
  logic              cry_d;

  always_comb begin
    vld_d = in_valid;
    if (imm_sel) begin
      opnd_d = imm_value;
      cry_d  = imm_carry;
    end else begin
      opnd_d = reg_value;
      cry_d  = reg_carry;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      operand   <= opnd_d;
      carry_out <= cry_d;
    end
  end

  // checks
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_imm_bits_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm_sel) |=>
      $countones(operand) == $countones($past(op_field[IMM8_W-1:0])));

  assert_imm_carry_zero_rot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm_sel && op_field[IMM8_W+ROTF_W-1:IMM8_W] == '0) |=>
      carry_out == $past(carry_in));

  assert_lsl0_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_sel && fld.kind == SK_LSL && !fld.amt_by_reg && fld.amt_imm == '0) |=>
      (operand == $past(rm_val) && carry_out == $past(carry_in)));

  assert_rrx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_sel && fld.kind == SK_ROR && !fld.amt_by_reg && fld.amt_imm == '0) |=>
      (operand[DATA_W-1] == $past(carry_in) && carry_out == $past(rm_val[0])));

  assert_reg_zero_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_sel && fld.amt_by_reg && amt_reg == '0) |=>
      (operand == $past(rm_val) && carry_out == $past(carry_in)));

  assert_ror_bits_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_sel && fld.kind == SK_ROR && fld.amt_by_reg) |=>
      $countones(operand) == $countones($past(rm_val)));

  assert_asr_big_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !imm_sel && fld.kind == SK_ASR && fld.amt_by_reg && amt_reg >= AMTR_W'(DATA_W)) |=>
      (operand == {DATA_W{carry_out}} && carry_out == $past(rm_val[DATA_W-1])));

endmodule

// File: tb/tb_opnd_shifter.sv
module tb_opnd_shifter;

  localparam time CLK_P = 4ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        imm_sel;
  logic [11:0] op_field;
  logic [31:0] rm_val;
  logic [7:0]  amt_reg;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] operand;
  logic        carry_out;

  always #(CLK_P/2) clk = ~clk;

  opnd_shifter dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .imm_sel   (imm_sel),
    .op_field  (op_field),
    .rm_val    (rm_val),
    .amt_reg   (amt_reg),
    .carry_in  (carry_in),
    .out_valid (out_valid),
    .operand   (operand),
    .carry_out (carry_out)
  );

  typedef struct {
    logic [31:0] val;
    logic        cy;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  function automatic logic [11:0] rf(input int amt, input int kind, input bit byreg);
    rf = {amt[4:0], kind[1:0], byreg, 4'h0};
  endfunction

  // reference model built from the requirements
  function automatic exp_t model(input bit isel, input logic [11:0] f,
                                 input logic [31:0] v, input logic [7:0] ra,
                                 input logic cin);
    exp_t        e;
    logic [63:0] dbl;
    logic [64:0] w;
    int          amt, n;
    bit          byreg;
    if (isel) begin
      n   = 2 * int'(f[11:8]);
      dbl = {24'b0, f[7:0], 24'b0, f[7:0]} >> n;
      e.val = dbl[31:0];
      e.cy  = (f[11:8] == 0) ? cin : e.val[31];
      e.tag = (f[11:8] == 0) ? "R2" : "R1";
      return e;
    end
    byreg = f[4];
    amt   = byreg ? int'(ra) : int'(f[11:7]);
    if (byreg && amt == 0) begin
      e.val = v; e.cy = cin; e.tag = "R6";
      return e;
    end
    case (f[6:5])
      2'd0: begin
        w = {33'b0, v} << amt;
        e.val = w[31:0]; e.cy = w[32];
        if (amt == 0) e.cy = cin;
        e.tag = byreg ? "R7" : "R3";
      end
      2'd1: begin
        if (!byreg && amt == 0) amt = 32;
        w = {v, 33'b0} >> amt;
        e.val = w[64:33]; e.cy = w[32];
        e.tag = byreg ? "R7" : "R4";
      end
      2'd2: begin
        if (!byreg && amt == 0) amt = 32;
        w = $signed({v, 33'b0}) >>> amt;
        e.val = w[64:33]; e.cy = w[32];
        e.tag = byreg ? "R8" : "R4";
      end
      default: begin
        if (!byreg && amt == 0) begin
          e.val = {cin, v[31:1]}; e.cy = v[0];
        end else begin
          n   = amt % 32;
          dbl = {v, v} >> n;
          e.val = dbl[31:0]; e.cy = e.val[31];
        end
        e.tag = byreg ? "R9" : "R5";
      end
    endcase
    return e;
  endfunction

  task automatic drive(input bit isel, input logic [11:0] f, input logic [31:0] v,
                       input logic [7:0] ra, input logic cin);
    @(posedge clk);
    #1;
    in_valid = 1'b1;
    imm_sel  = isel;
    op_field = f;
    rm_val   = v;
    amt_reg  = ra;
    carry_in = cin;
    exp_q.push_back(model(isel, f, v, ra, cin));
  endtask

  task automatic idle_check();
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    op_field = $urandom();
    @(posedge clk);
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 idle cycle: out_valid=%b expected 0", out_valid);
    end
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected out_valid: actual 1 expected 0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (operand !== e.val || carry_out !== e.cy) begin
          n_fail++;
          $display("FAIL %s operand=%h carry=%b expected operand=%h carry=%b",
                   e.tag, operand, carry_out, e.val, e.cy);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; imm_sel = 1'b0; op_field = '0;
    rm_val = '0; amt_reg = '0; carry_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 after reset: out_valid=%b expected 0", out_valid);
    end

    // R1 / R2: rotated immediates
    drive(1, {4'd0,  8'hFF}, '0, '0, 1'b1);
    drive(1, {4'd0,  8'h80}, '0, '0, 1'b0);
    drive(1, {4'd4,  8'hFF}, '0, '0, 1'b0);
    drive(1, {4'd15, 8'hFF}, '0, '0, 1'b1);
    drive(1, {4'd13, 8'h40}, '0, '0, 1'b1);
    drive(1, {4'd1,  8'h03}, '0, '0, 1'b0);
    // R3: left shift with field amount
    drive(0, rf(0, 0, 0),  32'h8000_0001, '0, 1'b1);
    drive(0, rf(1, 0, 0),  32'h8000_0001, '0, 1'b0);
    drive(0, rf(31, 0, 0), 32'h0000_0003, '0, 1'b0);
    // R4: right shifts with field amount, #0 meaning 32
    drive(0, rf(0, 1, 0),  32'h8000_0000, '0, 1'b0);
    drive(0, rf(4, 1, 0),  32'hF000_0018, '0, 1'b0);
    drive(0, rf(0, 2, 0),  32'h8000_0000, '0, 1'b0);
    drive(0, rf(0, 2, 0),  32'h7FFF_FFFF, '0, 1'b1);
    drive(0, rf(3, 2, 0),  32'h8000_0004, '0, 1'b0);
    // R5: rotate and rotate through carry
    drive(0, rf(0, 3, 0),  32'h0000_0001, '0, 1'b1);
    drive(0, rf(0, 3, 0),  32'h0000_0002, '0, 1'b0);
    drive(0, rf(8, 3, 0),  32'h1234_5680, '0, 1'b0);
    // R6: register amount zero
    for (int k = 0; k < 4; k++) drive(0, rf(17, k, 1), 32'hA5A5_0F0F, 8'd0, k[0]);
    // R7: logical shifts by 32 and beyond
    drive(0, rf(0, 0, 1), 32'h0000_0001, 8'd32,  1'b0);
    drive(0, rf(0, 0, 1), 32'hFFFF_FFFF, 8'd33,  1'b1);
    drive(0, rf(0, 1, 1), 32'h8000_0000, 8'd32,  1'b0);
    drive(0, rf(0, 1, 1), 32'hFFFF_FFFF, 8'd200, 1'b1);
    drive(0, rf(0, 1, 1), 32'h0000_0010, 8'd5,   1'b0);
    // R8: arithmetic shift by 32 or more
    drive(0, rf(0, 2, 1), 32'h8000_0000, 8'd32,  1'b0);
    drive(0, rf(0, 2, 1), 32'h9000_0000, 8'd255, 1'b0);
    drive(0, rf(0, 2, 1), 32'h7000_0000, 8'd40,  1'b1);
    // R9: register rotate modulo 32
    drive(0, rf(0, 3, 1), 32'h8000_0000, 8'd32,  1'b0);
    drive(0, rf(0, 3, 1), 32'h4000_0001, 8'd64,  1'b1);
    drive(0, rf(0, 3, 1), 32'h0000_00F1, 8'd36,  1'b0);
    drive(0, rf(0, 3, 1), 32'h0000_0001, 8'd1,   1'b0);
    // R10: idle gap produces no result
    idle_check();

    // mixed patterns across every form
    for (int i = 0; i < 400; i++) begin
      logic [31:0] v;
      logic [7:0]  ra;
      v  = $urandom();
      ra = (i % 3 == 0) ? 8'($urandom_range(0, 70)) : 8'($urandom());
      drive(i[0], 12'($urandom()), v, ra, 1'($urandom()));
      if (i % 50 == 49) idle_check();
    end

    @(posedge clk);
    #1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_run++;
      n_fail++;
      $display("FAIL R10 results missing: %0d outstanding expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule